// File: doc/BRIEF.md
# Burst Beat Address and Byte-Lane Walker

This block steps through one memory-mapped burst, one beat at a time. A start pulse captures the burst's first address, its beat-size code, its beat count minus one and its burst kind. From the next cycle on, the registered outputs present the address of the current beat, the lowest and highest active byte lanes on a data bus of parameterised width, a flag for the final beat, and a flag for a wrapping burst that is not aligned. Each advance pulse moves the outputs to the next beat.

The block is meant to sit inside a slave or master datapath. It is placed beside the logic that moves data and takes responses, and it supplies only the address and lane arithmetic. A short first beat is handled when the start address is unaligned. Wrapping bursts return to the bottom of their window. A fixed burst repeats its start address on every beat.

Top module: `burst_walker`

## Requirements
- R1: A cycle with `start` high loads the burst. From the next cycle `busy` is 1, `beat_addr` equals `start_addr`, and `last_beat` is 1 exactly when `burst_len` is 0. `start` takes priority over `advance` and restarts a burst that is still running.
- R2: A beat carries 2^`size_code` bytes. In an aligned burst of kind INCR (`burst_kind` 2'b01, and the unused code 2'b11 acts the same), each advance adds that byte count to `beat_addr`.
- R3: In a FIXED burst (`burst_kind` 2'b00), every beat keeps `start_addr` and the same lane pair.
- R4: On the first beat, and on every beat of a FIXED burst, `lane_lo` is the start address modulo the bus byte count. `lane_hi` is the start address rounded down to the beat size, taken modulo the bus byte count, plus the beat byte count minus 1. After an unaligned first beat, the next address is the rounded-down start plus one beat size.
- R5: On every beat after the first in a non-FIXED burst, `lane_lo` is `beat_addr` modulo the bus byte count and `lane_hi` is `lane_lo` plus the beat byte count minus 1.
- R6: A WRAP burst (`burst_kind` 2'b10) uses a window of (`burst_len`+1)·2^`size_code` bytes, where `burst_len`+1 must be 2, 4, 8 or 16. The window starts at `start_addr` rounded down to the window size. An aligned advance that reaches the window top reloads the window bottom.
- R7: `align_err` is 1 for the whole burst when the kind is WRAP and `start_addr` is not a multiple of the beat byte count. It is 0 for any other burst.
- R8: `last_beat` is 1 on the beat whose index, counted from 0, equals `burst_len`. An advance on that beat drops `busy` and `last_beat` and leaves the address and lanes unchanged.
- R9: After reset, all outputs are 0. An advance while `busy` is 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new burst |
| advance | input | 1 | Move to the next beat |
| start_addr | input | ADDR_W | First byte address of the burst |
| size_code | input | 3 | Beat size as log2 of bytes; must not exceed log2 of the bus byte count |
| burst_len | input | LEN_W | Number of beats minus one |
| burst_kind | input | 2 | 00 FIXED, 01 INCR, 10 WRAP, 11 as INCR |
| beat_addr | output | ADDR_W | Address of the current beat |
| lane_lo | output | LANE_W | Lowest active byte lane |
| lane_hi | output | LANE_W | Highest active byte lane |
| last_beat | output | 1 | Current beat is the final one |
| align_err | output | 1 | Unaligned WRAP burst |
| busy | output | 1 | A burst is in progress |

## Verification
The walker is exercised with several kinds of burst. Aligned word-size INCR bursts show the plain stride. Byte-size bursts that cross a bus word show the lane pointer rolling over. Unaligned word and halfword INCR bursts separate a short first beat from the snap to the aligned address. Fixed bursts, both aligned and unaligned, show that the address and lanes never move. Wrap bursts that start in the middle of their window, including a two-beat byte wrap, show the reload to the window bottom. An unaligned wrap must raise the error flag. Single-beat bursts, advances while idle and a restart in the middle of a burst cover the edges of the beat counter.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;
endpackage

// File: rtl/burst_lanes.sv
// Active byte lanes of one beat from the low address bits and the size.
module burst_lanes #(
  parameter int NB_LANES = 4,
  parameter int LANE_W   = 2
) (
  input  logic [LANE_W-1:0] addr_lo_bits,
  input  logic [2:0]        size,
  output logic [LANE_W-1:0] lo,
  output logic [LANE_W-1:0] hi
);
  generate
    if (NB_LANES > 1) begin : g_multi
      logic [LANE_W-1:0] m1;
      always_comb begin
        m1 = LANE_W'(({{LANE_W{1'b0}}, 1'b1} << size) - 1'b1);
        lo = addr_lo_bits;
        hi = (addr_lo_bits & ~m1) + m1;
      end
    end else begin : g_single
      assign lo = '0;
      assign hi = '0;
    end
  endgenerate
endmodule

// File: rtl/burst_step.sv
// Address of the following beat.
module burst_step
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [2:0]        size,
  input  logic [LEN_W-1:0]  len,
  input  burst_kind_e       kind,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] bpb, m1, total, tmask, lower;
  logic [ADDR_W:0]   inc, upper;
  logic              unal;

  always_comb begin
    bpb   = ADDR_W'(1) << size;
    m1    = bpb - ADDR_W'(1);
    unal  = |(cur_addr & m1);
    total = (ADDR_W'(len) + ADDR_W'(1)) << size;
    tmask = total - ADDR_W'(1);
    lower = first_addr & ~tmask;
    upper = {1'b0, lower} + {1'b0, total};
    inc   = {1'b0, cur_addr & ~m1} + {1'b0, bpb};
    case (kind)
      BK_FIXED: nxt_addr = cur_addr;
      BK_WRAP: begin
        if (!unal && inc >= upper) nxt_addr = lower;
        else                       nxt_addr = inc[ADDR_W-1:0];
      end
      default:  nxt_addr = inc[ADDR_W-1:0];
    endcase
  end
endmodule

// File: rtl/burst_walker.sv
module burst_walker
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  localparam int NB_LANES = DATA_W / 8,
  localparam int LANE_W   = (NB_LANES > 1) ? $clog2(NB_LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              advance,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        size_code,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [1:0]        burst_kind,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LANE_W-1:0] lane_lo,
  output logic [LANE_W-1:0] lane_hi,
  output logic              last_beat,
  output logic              align_err,
  output logic              busy
);
  burst_kind_e       kind_q;
  logic [2:0]        size_q;
  logic [LEN_W-1:0]  len_q, cnt_q, cnt_nx;
  logic [ADDR_W-1:0] first_q, nxt_addr, in_m1;
  logic [LANE_W-1:0] ld_lo, ld_hi, nx_lo, nx_hi;
  logic              in_unal;

  assign in_m1   = (ADDR_W'(1) << size_code) - ADDR_W'(1);
  assign in_unal = |(start_addr & in_m1);
  assign cnt_nx  = cnt_q + LEN_W'(1);

  burst_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
    .cur_addr  (beat_addr),
    .first_addr(first_q),
    .size      (size_q),
    .len       (len_q),
    .kind      (kind_q),
    .nxt_addr  (nxt_addr)
  );

  burst_lanes #(.NB_LANES(NB_LANES), .LANE_W(LANE_W)) u_lanes_load (
    .addr_lo_bits(start_addr[LANE_W-1:0]),
    .size        (size_code),
    .lo          (ld_lo),
    .hi          (ld_hi)
  );

  burst_lanes #(.NB_LANES(NB_LANES), .LANE_W(LANE_W)) u_lanes_next (
    .addr_lo_bits(nxt_addr[LANE_W-1:0]),
    .size        (size_q),
    .lo          (nx_lo),
    .hi          (nx_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= BK_FIXED;
      size_q    <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
      first_q   <= '0;
      beat_addr <= '0;
      lane_lo   <= '0;
      lane_hi   <= '0;
      last_beat <= 1'b0;
      align_err <= 1'b0;
      busy      <= 1'b0;
    end else if (start) begin
      kind_q    <= burst_kind_e'(burst_kind);
      size_q    <= size_code;
      len_q     <= burst_len;
      cnt_q     <= '0;
      first_q   <= start_addr;
      beat_addr <= start_addr;
      lane_lo   <= ld_lo;
      lane_hi   <= ld_hi;
      last_beat <= (burst_len == '0);
      align_err <= (burst_kind == BK_WRAP) && in_unal;
      busy      <= 1'b1;
    end else if (advance && busy) begin
      if (last_beat) begin
        busy      <= 1'b0;
        last_beat <= 1'b0;
      end else begin
        cnt_q     <= cnt_nx;
        beat_addr <= nxt_addr;
        lane_lo   <= nx_lo;
        lane_hi   <= nx_hi;
        last_beat <= (cnt_nx == len_q);
      end
    end
  end
endmodule

// File: rtl/burst_walker_chk.sv
module burst_walker_chk #(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              advance,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [LANE_W-1:0] lane_lo,
  input logic [LANE_W-1:0] lane_hi,
  input logic              last_beat,
  input logic              align_err,
  input logic              busy,
  input logic [1:0]        kind_q
);
  p_start_load_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && (beat_addr == $past(start_addr)));

  p_fixed_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && advance && kind_q == 2'b00) |=> $stable(beat_addr) && $stable(lane_lo));

  p_lane_order_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> lane_lo <= lane_hi);

  p_err_wrap_only_r7: assert property (@(posedge clk) disable iff (rst)
    align_err |-> kind_q == 2'b10);

  p_end_of_burst_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && last_beat && advance && !start) |=> !busy && !last_beat && $stable(beat_addr));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy && $stable(beat_addr) && $stable(lane_hi));
endmodule

bind burst_walker burst_walker_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .advance   (advance),
  .start_addr(start_addr),
  .beat_addr (beat_addr),
  .lane_lo   (lane_lo),
  .lane_hi   (lane_hi),
  .last_beat (last_beat),
  .align_err (align_err),
  .busy      (busy),
  .kind_q    (kind_q)
);

// File: tb/burst_walker_test.sv
`timescale 1ns/1ps
module burst_walker_test;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 8;
  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, advance = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [2:0]        size_code = '0;
  logic [LEN_W-1:0]  burst_len = '0;
  logic [1:0]        burst_kind = '0;
  logic [ADDR_W-1:0] beat_addr;
  logic [LANE_W-1:0] lane_lo, lane_hi;
  logic              last_beat, align_err, busy;

  always #10 clk = ~clk;

  burst_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .start(start), .advance(advance),
    .start_addr(start_addr), .size_code(size_code), .burst_len(burst_len),
    .burst_kind(burst_kind), .beat_addr(beat_addr), .lane_lo(lane_lo),
    .lane_hi(lane_hi), .last_beat(last_beat), .align_err(align_err), .busy(busy)
  );

  typedef struct {
    int    due;
    int    addr, lo, hi;
    bit    last, err, bsy;
    string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // independent reference state
  int m_start, m_addr, m_size, m_len, m_kind, m_cnt, m_lo, m_hi;
  bit m_busy, m_last, m_err, m_aligned;

  function automatic int bpb(); return 1 << m_size; endfunction

  function automatic void first_lanes();
    int al;
    al   = (m_start / bpb()) * bpb();
    m_lo = m_start % NB;
    m_hi = al + bpb() - 1 - (m_start / NB) * NB;
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.due = cyc + 1; e.addr = m_addr; e.lo = m_lo; e.hi = m_hi;
    e.last = m_last; e.err = m_err; e.bsy = m_busy; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_start(int a, int sz, int ln, int k, string tag);
    @(posedge clk); #2;
    start = 1'b1; advance = 1'b0;
    start_addr = ADDR_W'(a); size_code = 3'(sz); burst_len = LEN_W'(ln); burst_kind = 2'(k);
    m_start = a; m_addr = a; m_size = sz; m_len = ln; m_kind = k; m_cnt = 0;
    m_busy = 1; m_last = (ln == 0);
    m_aligned = (a % (1 << sz)) == 0;
    m_err = (k == 2) && !m_aligned;
    first_lanes();
    push(tag);
  endtask

  task automatic do_adv(string tag);
    int tot, lower;
    @(posedge clk); #2;
    start = 1'b0; advance = 1'b1;
    if (m_busy) begin
      if (m_last) begin
        m_busy = 0; m_last = 0;
      end else begin
        if (m_kind != 0) begin
          if (!m_aligned) begin
            m_addr = (m_start / bpb()) * bpb() + bpb();
            m_aligned = 1;
          end else begin
            m_addr = m_addr + bpb();
            if (m_kind == 2) begin
              tot   = bpb() * (m_len + 1);
              lower = (m_start / tot) * tot;
              if (m_addr >= lower + tot) m_addr = lower;
            end
          end
          m_addr = m_addr % (1 << ADDR_W);
          m_lo = m_addr % NB;
          m_hi = m_lo + bpb() - 1;
        end else begin
          first_lanes();
        end
        m_cnt = m_cnt + 1;
        m_last = (m_cnt == m_len);
      end
    end
    push(tag);
  endtask

  task automatic do_idle(string tag);
    @(posedge clk); #2;
    start = 1'b0; advance = 1'b0;
    push(tag);
  endtask

  // monitor: compare every due expectation
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.due != cyc || busy !== e.bsy || int'(beat_addr) != e.addr ||
          int'(lane_lo) != e.lo || int'(lane_hi) != e.hi ||
          last_beat !== e.last || align_err !== e.err) begin
        errors++;
        $display("FAIL %s: got busy=%0b addr=%h lo=%0d hi=%0d last=%0b err=%0b, expected busy=%0b addr=%h lo=%0d hi=%0d last=%0b err=%0b",
                 e.tag, busy, beat_addr, lane_lo, lane_hi, last_beat, align_err,
                 e.bsy, e.addr[ADDR_W-1:0], e.lo, e.hi, e.last, e.err);
      end
    end
  end

  task automatic run_burst(int a, int sz, int ln, int k, string tag);
    do_start(a, sz, ln, k, tag);
    for (int i = 0; i <= ln; i++) do_adv(tag);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_start = 0; m_addr = 0; m_size = 0; m_len = 0; m_kind = 0; m_cnt = 0;
    m_lo = 0; m_hi = 0; m_busy = 0; m_last = 0; m_err = 0; m_aligned = 1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || beat_addr !== '0 || lane_lo !== '0 || lane_hi !== '0 ||
        last_beat !== 1'b0 || align_err !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: got busy=%0b addr=%h, expected all zero", busy, beat_addr);
    end
    do_adv("R9 advance while idle");
    do_idle("R9 idle hold");
    run_burst(16'h0100, 2, 3, 1, "R2 R8 aligned INCR word");
    do_idle("R8 idle after end");
    run_burst(16'h0021, 0, 5, 1, "R5 INCR byte rollover");
    run_burst(16'h0203, 2, 2, 1, "R4 unaligned INCR word");
    run_burst(16'h0035, 1, 2, 1, "R4 R5 unaligned INCR half");
    run_burst(16'h0042, 1, 3, 0, "R3 FIXED half");
    run_burst(16'h0051, 2, 2, 0, "R3 R4 FIXED unaligned");
    run_burst(16'h0038, 2, 3, 2, "R6 WRAP word mid window");
    run_burst(16'h0007, 0, 1, 2, "R6 WRAP two byte");
    run_burst(16'h00F4, 2, 7, 2, "R6 WRAP eight beat");
    run_burst(16'h003A, 2, 3, 2, "R7 unaligned WRAP error");
    run_burst(16'h0044, 2, 3, 2, "R7 aligned WRAP no error");
    run_burst(16'h0300, 1, 2, 3, "R2 reserved kind as INCR");
    run_burst(16'h0123, 1, 0, 1, "R1 R8 single beat");
    do_start(16'h0400, 2, 7, 1, "R1 restart first");
    do_adv("R1 restart mid");
    do_adv("R1 restart mid");
    do_start(16'h0502, 0, 2, 1, "R1 restart mid-burst");
    do_adv("R1 after restart");
    do_adv("R1 after restart");
    do_adv("R8 after restart end");
    do_idle("R9 final idle");
    do_adv("R9 final idle advance");
    repeat (4) @(posedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending, expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule